// File: doc/BRIEF.md
# Power Domain Sequencer

This block is a hardware state machine that brings a display/video power domain up and down in a fixed, safe order. On a power-off request it isolates the domain outputs, powers down the domain's memories a small group at a time with a settle wait after every group, opens the main power switch, waits a long time for the rail to collapse, and finally gates both domain clocks. On a power-on request it closes the switch first, wakes the memories in the same group order, then pulses the domain reset around the release of isolation and enables the two clocks, the main clock before the bus clock.

All waits are counted in ticks of a free-running microsecond strobe, so the sequence timing is independent of the core clock frequency. The memory power-down vector is made of two or three 32-bit banks stepped two bits at a time, followed by eight auxiliary controls stepped one bit at a time; a parameter chooses whether the third bank exists. A strap sampled during reset tells the block whether the domain is already powered, so that the clock enables match the real state from the first cycle. A busy flag covers each running sequence and a one-cycle done pulse marks its end.

Top module: `pwr_dom_seq`

## Requirements
- R1: While reset is held with `boot_on_i` low, the outputs settle to: `pwr_down_o`=1, `iso_o`=1, every `mem_pd_o` bit 1, `reset_o`=0, both clock enables 0, `busy_o`=0, `done_o`=0; with `boot_on_i` high: `pwr_down_o`=0, `iso_o`=0, every `mem_pd_o` bit 0, `reset_o`=0, both clock enables 1.
- R2: An accepted power-off request raises `iso_o` on the first clock edge, and the first memory group changes HEAD_TICKS ticks plus one clock after that edge.
- R3: Memory groups are visited one per step in this order: two-bit pairs of bank 0 from bits [1:0] upward, then bank 1, then bank 2 when present (bank k occupies `mem_pd_o[32k+31:32k]`), then the eight auxiliary controls in the top eight bits of `mem_pd_o`, lowest first; consecutive steps are STEP_TICKS ticks plus one clock apart and no step changes more than two bits.
- R4: With EXT_BANK=0 `mem_pd_o` is 72 bits wide and a sequence takes 40 steps; with EXT_BANK=1 it is 104 bits wide and takes 56 steps.
- R5: On power-off, `pwr_down_o` rises STEP_TICKS+TAIL_TICKS ticks plus one clock after the last memory step, and both clock enables fall together SWITCH_TICKS ticks plus one clock after that.
- R6: An accepted power-on request clears `pwr_down_o` on the first clock edge and then clears the memory groups in the R3 order and spacing, the first one HEAD_TICKS ticks plus one clock later.
- R7: On power-on, `reset_o` rises STEP_TICKS+TAIL_TICKS ticks plus one clock after the last memory step; on the following four clock edges, in turn, `iso_o` falls, `reset_o` falls, `clk_main_en_o` rises, and `clk_bus_en_o` rises.
- R8: `dom_on_o` is the inverse of `pwr_down_o`; `busy_o` is high from the edge that accepts a request until the edge that ends its sequence.
- R9: Wait counters advance only on clock edges where `tick_i` is high; with `tick_i` held low a sequence holds its place and every later event shifts by the number of stalled ticks.
- R10: Requests that arrive while `busy_o` is high are ignored and do not alter the running sequence or its timing.
- R11: A request that matches the present state (power-on while on, power-off while off) raises `done_o` on the next edge and changes no other output; `req_off_i` wins when both requests arrive together.
- R12: `done_o` is a single-cycle pulse raised on the edge that ends a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| boot_on_i | input | 1 | Strap: domain already powered, sampled while in reset |
| tick_i | input | 1 | One-cycle microsecond strobe that advances waits |
| req_on_i | input | 1 | Power-on request pulse |
| req_off_i | input | 1 | Power-off request pulse |
| pwr_down_o | output | 1 | Domain power switch, 1 = switched off |
| iso_o | output | 1 | Domain output isolation, 1 = isolated |
| mem_pd_o | output | MEM_W | Memory power-down controls, 1 = powered down |
| reset_o | output | 1 | Domain reset, active high |
| clk_main_en_o | output | 1 | Main domain clock enable |
| clk_bus_en_o | output | 1 | Domain bus clock enable |
| dom_on_o | output | 1 | Domain status, 1 = powered |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
The assertions assume that power requests are single-cycle pulses, that `boot_on_i` is stable while reset is low, and that `tick_i` is synchronous to `clk_i`; a held request would legitimately yield back-to-back done pulses and trip the done-width check. The stimulus only ever drives each request for one cycle, changes the strap only inside reset, and drives the tick either continuously or in an explicit stalled window, so that every expected event offset can be computed from the tick counts. Requests aimed at a busy sequence are injected mid-sequence as pulses to confirm they are dropped.

// File: rtl/pds_pkg.sv
// Package for the power domain sequencer.
// Holds the sequencer state encoding and small elaboration helpers.
package pds_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_STEP,
        ST_STEP_WAIT,
        ST_TAIL,
        ST_SWITCH,
        ST_SW_WAIT,
        ST_CLK_OFF,
        ST_RST_SET,
        ST_ISO_CLR,
        ST_RST_CLR,
        ST_CLK_MAIN,
        ST_CLK_BUS
    } seq_state_e;

    // Larger of two wait lengths, used to size the shared counter.
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pds_tick_timer.sv
// Shared wait counter for the power domain sequencer.
// Loaded with a tick count when a wait starts, decremented on each tick
// while a wait state is active; expire_o flags the tick that ends the wait.
// Assumes load values are at least 1 and load wins over decrement.
module pds_tick_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: hold the remaining tick count of the current wait.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_i && tick_i && (cnt_q == CNT_W'(1));

    // R9
    cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q != '0));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pds_group_mask.sv
// Memory group decoder for the power domain sequencer.
// Turns a step index into the set of power-down bits touched by that step:
// two-bit pairs across the banks first, then single auxiliary bits.
// Assumes idx_i never exceeds the last group index.
module pds_group_mask #(
    parameter int MEM_W     = 72,
    parameter int PAIR_BITS = 64,
    parameter int GRP_W     = 2,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [MEM_W-1:0] mask_o
);

    localparam int PAIR_GROUPS = PAIR_BITS / GRP_W;

    // Purpose: one comparator per bit selects that bit's owning step.
    for (genvar b = 0; b < MEM_W; b++) begin : g_bit
        if (b < PAIR_BITS) begin : g_pair
            assign mask_o[b] = (idx_i == IDX_W'(b / GRP_W));
        end else begin : g_aux
            assign mask_o[b] = (idx_i == IDX_W'(PAIR_GROUPS + b - PAIR_BITS));
        end
    end

endmodule

// File: rtl/pwr_dom_seq.sv
// Power domain sequencer top.
// Runs the power-off order (isolate, memories down by group, switch off,
// long settle, clocks off) and the power-on order (switch on, memories up
// by group, reset around isolation release, main clock then bus clock).
// Assumes requests are one-cycle pulses, tick_i is synchronous to clk_i
// and boot_on_i is stable while rst_ni is low.
module pwr_dom_seq
    import pds_pkg::*;
#(
    parameter int BANK_W       = 32,
    parameter int GRP_W        = 2,
    parameter int AUX_CTRL     = 8,
    parameter bit EXT_BANK     = 1'b0,
    parameter int HEAD_TICKS   = 20,
    parameter int STEP_TICKS   = 5,
    parameter int TAIL_TICKS   = 20,
    parameter int SWITCH_TICKS = 20000,
    localparam int NBANK       = EXT_BANK ? 3 : 2,
    localparam int MEM_W       = NBANK * BANK_W + AUX_CTRL
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             boot_on_i,
    input  logic             tick_i,
    input  logic             req_on_i,
    input  logic             req_off_i,
    output logic             pwr_down_o,
    output logic             iso_o,
    output logic [MEM_W-1:0] mem_pd_o,
    output logic             reset_o,
    output logic             clk_main_en_o,
    output logic             clk_bus_en_o,
    output logic             dom_on_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int PAIR_BITS = NBANK * BANK_W;
    localparam int NGRP      = PAIR_BITS / GRP_W + AUX_CTRL;
    localparam int IDX_W     = $clog2(NGRP);
    localparam int MAXT      = int'(max2(max2(HEAD_TICKS, STEP_TICKS),
                                         max2(TAIL_TICKS, SWITCH_TICKS)));
    localparam int CNT_W     = $clog2(MAXT + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NGRP - 1);

    seq_state_e       state_q;
    logic             dir_off_q;
    logic [IDX_W-1:0] idx_q;
    logic             pwr_down_q, iso_q, rst_q, cm_q, cb_q, done_q;
    logic [MEM_W-1:0] mem_q;
    logic [MEM_W-1:0] grp_mask;
    logic             want_off, want_on;
    logic             tmr_load, tmr_run, tmr_expire;
    logic [CNT_W-1:0] tmr_val;

    pds_group_mask #(
        .MEM_W     (MEM_W),
        .PAIR_BITS (PAIR_BITS),
        .GRP_W     (GRP_W),
        .IDX_W     (IDX_W)
    ) u_mask (
        .idx_i  (idx_q),
        .mask_o (grp_mask)
    );

    pds_tick_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .tick_i     (tick_i),
        .expire_o   (tmr_expire)
    );

    // Purpose: decide which request, if any, starts a sequence this cycle.
    always_comb begin
        want_off = (state_q == ST_IDLE) && req_off_i && !pwr_down_q;
        want_on  = (state_q == ST_IDLE) && !req_off_i && req_on_i && pwr_down_q;
    end

    // Purpose: pick the wait length to load and mark the waiting states.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_run  = (state_q == ST_HEAD) || (state_q == ST_STEP_WAIT) ||
                   (state_q == ST_TAIL) || (state_q == ST_SW_WAIT);
        case (state_q)
            ST_IDLE: begin
                if (want_off || want_on) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HEAD_TICKS);
                end
            end
            ST_STEP: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(STEP_TICKS);
            end
            ST_STEP_WAIT: begin
                if (tmr_expire && idx_q == LAST_IDX) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TAIL_TICKS);
                end
            end
            ST_SWITCH: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SWITCH_TICKS);
            end
            default: ;
        endcase
    end

    // Purpose: sequencer state and all registered domain controls.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q    <= ST_IDLE;
            dir_off_q  <= 1'b0;
            idx_q      <= '0;
            pwr_down_q <= !boot_on_i;
            iso_q      <= !boot_on_i;
            mem_q      <= {MEM_W{!boot_on_i}};
            rst_q      <= 1'b0;
            cm_q       <= boot_on_i;
            cb_q       <= boot_on_i;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (req_off_i) begin
                        if (pwr_down_q) begin
                            done_q <= 1'b1;
                        end else begin
                            dir_off_q <= 1'b1;
                            iso_q     <= 1'b1;
                            state_q   <= ST_HEAD;
                        end
                    end else if (req_on_i) begin
                        if (!pwr_down_q) begin
                            done_q <= 1'b1;
                        end else begin
                            dir_off_q  <= 1'b0;
                            pwr_down_q <= 1'b0;
                            state_q    <= ST_HEAD;
                        end
                    end
                end
                ST_HEAD: if (tmr_expire) state_q <= ST_STEP;
                ST_STEP: begin
                    mem_q   <= dir_off_q ? (mem_q | grp_mask) : (mem_q & ~grp_mask);
                    state_q <= ST_STEP_WAIT;
                end
                ST_STEP_WAIT: begin
                    if (tmr_expire) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= ST_TAIL;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_STEP;
                        end
                    end
                end
                ST_TAIL: if (tmr_expire) state_q <= dir_off_q ? ST_SWITCH : ST_RST_SET;
                ST_SWITCH: begin
                    pwr_down_q <= 1'b1;
                    state_q    <= ST_SW_WAIT;
                end
                ST_SW_WAIT: if (tmr_expire) state_q <= ST_CLK_OFF;
                ST_CLK_OFF: begin
                    cm_q    <= 1'b0;
                    cb_q    <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_RST_SET: begin
                    rst_q   <= 1'b1;
                    state_q <= ST_ISO_CLR;
                end
                ST_ISO_CLR: begin
                    iso_q   <= 1'b0;
                    state_q <= ST_RST_CLR;
                end
                ST_RST_CLR: begin
                    rst_q   <= 1'b0;
                    state_q <= ST_CLK_MAIN;
                end
                ST_CLK_MAIN: begin
                    cm_q    <= 1'b1;
                    state_q <= ST_CLK_BUS;
                end
                ST_CLK_BUS: begin
                    cb_q    <= 1'b1;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pwr_down_o    = pwr_down_q;
    assign iso_o         = iso_q;
    assign mem_pd_o      = mem_q;
    assign reset_o       = rst_q;
    assign clk_main_en_o = cm_q;
    assign clk_bus_en_o  = cb_q;
    assign dom_on_o      = !pwr_down_q;
    assign busy_o        = (state_q != ST_IDLE);
    assign done_o        = done_q;

    // R2
    mem_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_q != $past(mem_q)) |-> iso_q);

    // R3
    step_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(mem_q ^ $past(mem_q)) <= GRP_W);

    // R7
    iso_rel_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(iso_q) |-> rst_q);

    // R7
    bus_after_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cb_q) |-> cm_q);

    // R12
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q |=> !done_q);

    // R12
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q |-> (state_q == ST_IDLE));

endmodule

// File: tb/pwr_dom_seq_tb_top.sv
// Self-checking bench for the power domain sequencer.
// A table of operations is walked first, then directed tests cover
// tick stalls, requests during a sequence and the narrow variant.
module pwr_dom_seq_tb_top;

    localparam int H = 4;
    localparam int S = 2;
    localparam int T = 3;
    localparam int L = 10;
    localparam int MEM_A = 3 * 32 + 8;
    localparam int MEM_B = 2 * 32 + 8;
    localparam int N_A = 56;
    localparam int N_B = 40;
    localparam int WD_CYCLES = 150000;

    // Expected sequence lengths (edges from accept to done), tick every cycle.
    function automatic int d_off(int n);
        return H + n * (S + 1) + T + L + 2;
    endfunction
    function automatic int d_on(int n);
        return H + n * (S + 1) + T + 5;
    endfunction
    function automatic logic [MEM_A-1:0] exp_mask(int n);
        logic [MEM_A-1:0] m;
        m = '0;
        if (n < 48) m[2*n +: 2] = 2'b11;
        else        m[96 + n - 48] = 1'b1;
        return m;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_on = 1'b0;
    logic tick = 1'b1;
    logic req_on_a = 1'b0, req_off_a = 1'b0;
    logic req_on_b = 1'b0, req_off_b = 1'b0;

    logic pd_a, iso_a, rst_a, cm_a, cb_a, on_a, busy_a, done_a;
    logic [MEM_A-1:0] mem_a;
    logic pd_b, iso_b, rst_b, cm_b, cb_b, on_b, busy_b, done_b;
    logic [MEM_B-1:0] mem_b;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_dom_seq #(
        .EXT_BANK (1'b1), .HEAD_TICKS (H), .STEP_TICKS (S),
        .TAIL_TICKS (T), .SWITCH_TICKS (L)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .boot_on_i (boot_on), .tick_i (tick),
        .req_on_i (req_on_a), .req_off_i (req_off_a),
        .pwr_down_o (pd_a), .iso_o (iso_a), .mem_pd_o (mem_a), .reset_o (rst_a),
        .clk_main_en_o (cm_a), .clk_bus_en_o (cb_a), .dom_on_o (on_a),
        .busy_o (busy_a), .done_o (done_a)
    );

    pwr_dom_seq #(
        .EXT_BANK (1'b0), .HEAD_TICKS (H), .STEP_TICKS (S),
        .TAIL_TICKS (T), .SWITCH_TICKS (L)
    ) dut_b (
        .clk_i (clk), .rst_ni (rst_n), .boot_on_i (boot_on), .tick_i (tick),
        .req_on_i (req_on_b), .req_off_i (req_off_b),
        .pwr_down_o (pd_b), .iso_o (iso_b), .mem_pd_o (mem_b), .reset_o (rst_b),
        .clk_main_en_o (cm_b), .clk_bus_en_o (cb_b), .dom_on_o (on_b),
        .busy_o (busy_b), .done_o (done_b)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Event records for one operation on dut_i (offsets in edges from accept).
    logic [MEM_A-1:0] p_mem;
    logic p_iso, p_pd, p_rst, p_cm, p_cb;
    int t_iso, t_pd, t_rst_up, t_rst_dn, t_cm, t_cb, t_done;
    int t_mfirst, t_mlast, n_mem, n_evt, n_done, n_busy, mask_err;

    task automatic clear_rec();
        p_mem = mem_a; p_iso = iso_a; p_pd = pd_a; p_rst = rst_a;
        p_cm = cm_a; p_cb = cb_a;
        t_iso = -1; t_pd = -1; t_rst_up = -1; t_rst_dn = -1; t_cm = -1;
        t_cb = -1; t_done = -1; t_mfirst = -1; t_mlast = -1;
        n_mem = 0; n_evt = 0; n_done = 0; n_busy = 0; mask_err = 0;
    endtask

    task automatic sample(input int off);
        if (mem_a != p_mem) begin
            if (n_mem == 0) t_mfirst = off;
            t_mlast = off;
            if ((mem_a ^ p_mem) != exp_mask(n_mem)) mask_err++;
            n_mem++; n_evt++;
        end
        if (iso_a != p_iso) begin t_iso = off; n_evt++; end
        if (pd_a != p_pd) begin t_pd = off; n_evt++; end
        if (rst_a && !p_rst) begin t_rst_up = off; n_evt++; end
        if (!rst_a && p_rst) begin t_rst_dn = off; n_evt++; end
        if (cm_a != p_cm) begin t_cm = off; n_evt++; end
        if (cb_a != p_cb) begin t_cb = off; n_evt++; end
        if (done_a) begin
            if (n_done == 0) t_done = off;
            n_done++;
        end
        if (busy_a) n_busy++;
        p_mem = mem_a; p_iso = iso_a; p_pd = pd_a; p_rst = rst_a;
        p_cm = cm_a; p_cb = cb_a;
    endtask

    // Issue one request on dut_i; stall = ticks held low after accept,
    // poke = offset at which the opposite request is pulsed (-1 none).
    task automatic run_a(input bit off_req, input int stall, input int poke);
        int start;
        int opp_was;
        @(negedge clk);
        clear_rec();
        if (off_req) req_off_a = 1'b1; else req_on_a = 1'b1;
        @(negedge clk);
        req_off_a = 1'b0; req_on_a = 1'b0;
        start = cyc;
        opp_was = 0;
        for (int k = 0; k < 1000; k++) begin
            if (k > 0) @(negedge clk);
            sample(cyc - start);
            if (stall > 0 && k == stall) begin
                chk(n_mem == 0, "R9 no memory step while tick low", n_mem, 0);
            end
            tick = ((cyc - start) >= stall);
            if (off_req) req_on_a = ((cyc - start) == poke);
            else         req_off_a = ((cyc - start) == poke);
            if (t_done >= 0 && (cyc - start) > t_done) break;
        end
        req_on_a = 1'b0; req_off_a = 1'b0; tick = 1'b1;
    endtask

    task automatic check_final(input bit exp_on, input string tag);
        chk(on_a == exp_on, {tag, " dom_on"}, on_a, exp_on);
        chk(pd_a == !exp_on, {tag, " pwr_down"}, pd_a, !exp_on);
        chk(iso_a == !exp_on, {tag, " iso"}, iso_a, !exp_on);
        chk(mem_a == {MEM_A{!exp_on}}, {tag, " mem_pd"}, mem_a[31:0], exp_on ? 0 : 32'hffffffff);
        chk(cm_a == exp_on && cb_a == exp_on, {tag, " clocks"}, {cm_a, cb_a}, {exp_on, exp_on});
        chk(!rst_a && !busy_a, {tag, " reset/busy low"}, {rst_a, busy_a}, 0);
    endtask

    task automatic check_run(input bit off_req, input int stall);
        int last;
        last = H + 1 + (N_A - 1) * (S + 1) + stall;
        chk(n_done == 1, "R12 single done pulse", n_done, 1);
        chk(n_mem == N_A, "R4 step count extended", n_mem, N_A);
        chk(mask_err == 0, "R3 group order", mask_err, 0);
        chk(t_mfirst == H + 1 + stall, "R2/R6 first memory step", t_mfirst, H + 1 + stall);
        chk(t_mlast == last, "R3 step spacing", t_mlast, last);
        if (off_req) begin
            chk(t_iso == 0, "R2 iso first", t_iso, 0);
            chk(t_pd == last + S + T + 1, "R5 switch off", t_pd, last + S + T + 1);
            chk(t_cm == t_pd + L + 1 && t_cb == t_cm, "R5 clocks drop", t_cm, t_pd + L + 1);
            chk(t_done == d_off(N_A) + stall, "R12 done at end off", t_done, d_off(N_A) + stall);
            chk(n_busy == d_off(N_A) + stall, "R8 busy span", n_busy, d_off(N_A) + stall);
        end else begin
            chk(t_pd == 0, "R6 switch on first", t_pd, 0);
            chk(t_rst_up == last + S + T + 1, "R7 reset assert", t_rst_up, last + S + T + 1);
            chk(t_iso == t_rst_up + 1, "R7 iso release", t_iso, t_rst_up + 1);
            chk(t_rst_dn == t_rst_up + 2, "R7 reset release", t_rst_dn, t_rst_up + 2);
            chk(t_cm == t_rst_up + 3, "R7 main clock", t_cm, t_rst_up + 3);
            chk(t_cb == t_rst_up + 4, "R7 bus clock", t_cb, t_rst_up + 4);
            chk(t_done == d_on(N_A) + stall, "R12 done at end on", t_done, d_on(N_A) + stall);
            chk(n_busy == d_on(N_A) + stall, "R8 busy span", n_busy, d_on(N_A) + stall);
        end
    endtask

    // Table: {expect_run, op_is_off}
    localparam logic [1:0] OPS [6] = '{2'b10, 2'b00, 2'b11, 2'b01, 2'b10, 2'b11};

    task automatic run_b(input bit off_req);
        int start, n, td;
        logic [MEM_B-1:0] pm;
        n = 0; td = -1;
        @(negedge clk);
        pm = mem_b;
        if (off_req) req_off_b = 1'b1; else req_on_b = 1'b1;
        @(negedge clk);
        req_off_b = 1'b0; req_on_b = 1'b0;
        start = cyc;
        for (int k = 0; k < 1000 && td < 0; k++) begin
            if (k > 0) @(negedge clk);
            if (mem_b != pm) n++;
            pm = mem_b;
            if (done_b) td = cyc - start;
        end
        chk(n == N_B, "R4 step count narrow", n, N_B);
        chk(td == (off_req ? d_off(N_B) : d_on(N_B)), "R4 narrow length", td,
            off_req ? d_off(N_B) : d_on(N_B));
        chk(on_b == !off_req, "R4 narrow final state", on_b, !off_req);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait (cyc >= WD_CYCLES);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_CYCLES);
        finish_run();
    end

    initial begin
        // R1 boot powered
        boot_on = 1'b1; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(on_a && !pd_a && !iso_a && mem_a == '0, "R1 boot-on domain", {pd_a, iso_a}, 0);
        chk(cm_a && cb_a && !rst_a, "R1 boot-on clocks", {cm_a, cb_a, rst_a}, 3'b110);
        chk(!busy_a && !done_a, "R1 boot-on idle", {busy_a, done_a}, 0);
        // R1 boot unpowered
        rst_n = 1'b0; boot_on = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!on_a && pd_a && iso_a && mem_a == {MEM_A{1'b1}}, "R1 boot-off domain", {pd_a, iso_a}, 3);
        chk(!cm_a && !cb_a && !rst_a, "R1 boot-off clocks", {cm_a, cb_a, rst_a}, 0);
        chk(mem_b == {MEM_B{1'b1}} && $bits(mem_b) == 72, "R4 narrow width", $bits(mem_b), 72);
        chk($bits(mem_a) == 104, "R4 extended width", $bits(mem_a), 104);

        // Table walk
        for (int i = 0; i < 6; i++) begin
            run_a(OPS[i][0], 0, -1);
            if (OPS[i][1]) begin
                check_run(OPS[i][0], 0);
            end else begin
                chk(t_done == 0 && n_done == 1, "R11 matching request done", t_done, 0);
                chk(n_evt == 0 && n_busy == 0, "R11 matching request no change", n_evt, 0);
            end
            check_final(!OPS[i][0], "R8 final state");
        end

        // R9 stalled ticks during power-on
        run_a(1'b0, 7, -1);
        check_run(1'b0, 7);
        check_final(1'b1, "R9 after stall");

        // R10 power-on pulse while powering off is ignored
        run_a(1'b1, 0, 30);
        check_run(1'b1, 0);
        check_final(1'b0, "R10 after ignored request");

        // R4 narrow variant
        run_b(1'b0);
        run_b(1'b1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule